// File: doc/BRIEF.md
# Programmable Clock Output Divider

This block derives an auxiliary clock from the system clock. A 3-bit select picks one of eight ratios: 1, 2, 3, 4, 6, 8, 12 or 16. An enable bit turns the output on and off. The output is meant for a pad that it shares with the master-clock input function. A pin-direction flag tells the block when that pad is an input. While the flag is set, the pad output-enable is blocked and the divider is stopped.

The enable request, already qualified by the pin-direction flag, passes through a two-stage synchroniser before it starts the divider. The select is treated as a quasi-static setting in the system clock domain.

- Even ratios come from a single counter on the rising edge.
- Divide-by-3 adds one falling-edge flop to get a 50% duty cycle.
- Divide-by-1 passes the system clock through a glitch-free gate.

A new ratio is loaded only when the current output period ends, so a ratio change never makes a shortened pulse.

Top module: `clk_out_div`

## Requirements
- R1: The select `ratio_sel_i` maps to a divisor N as follows: 000→1, 001→2, 010→3, 011→4, 100→6, 101→8, 110→12, 111→16.
- R2: While running, `clk_o` has a period of N system-clock cycles and a high time of N/2 cycles.
  - For N=3 the high time is 1.5 cycles.
  - For N=1 the output follows the system clock.
- R3: While `rst_ni` is low, `clk_o` and `pin_oe_o` are low. After reset, with `en_i` low, both stay low.
- R4: After `en_i` goes low, `clk_o` and `pin_oe_o` are low within three system-clock edges. They then stay low for as long as `en_i` stays low.
- R5: `en_i` may be raised between two rising edges of the system clock. With an even N≥2:
  - `pin_oe_o` goes high after the 2nd rising edge that follows.
  - A fresh period starts with `clk_o` low.
  - The first rising edge of `clk_o` lands on the (2+N/2)-th rising edge.
- R6: While `pin_is_input_i` is high, `pin_oe_o` is low and the divider does not run.
- R7: A change of `ratio_sel_i` takes effect only at the end of the current output period. The period in progress completes with its old high time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Output enable request |
| ratio_sel_i | input | 3 | Divide ratio select (R1 encoding) |
| pin_is_input_i | input | 1 | Shared pad is configured as master-clock input |
| clk_o | output | 1 | Divided clock |
| pin_oe_o | output | 1 | Pad output-enable |

## Verification
The bench measures the high time and the period of `clk_o` for every select code.
- A design without the falling-edge flop would give divide-by-3 a 1-of-3 or 2-of-3 duty cycle.
- A broken divide-by-1 gate would give no pulses or a split pulse.

A select change is made in the middle of a divide-by-16 period:
- A design that loaded the ratio at once would cut the 64 ns high phase short.
- A correct design yields one 72 ns transition period before the divide-by-2 periods.

The bench times the first output edge after enable, which catches a wrong synchroniser depth or a period that starts high. It also holds the pad as an input with the enable set, which catches an output-enable that ignores the interlock.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  localparam int SEL_W   = 3;
  localparam int MAX_DIV = 16;
  localparam int DIV_W   = $clog2(MAX_DIV + 1);
  localparam int CNT_W   = $clog2(MAX_DIV);

  function automatic logic [DIV_W-1:0] ratio_f(input logic [SEL_W-1:0] sel);
    logic [DIV_W-1:0] r;
    case (sel)
      3'd0:    r = DIV_W'(1);
      3'd1:    r = DIV_W'(2);
      3'd2:    r = DIV_W'(3);
      3'd3:    r = DIV_W'(4);
      3'd4:    r = DIV_W'(6);
      3'd5:    r = DIV_W'(8);
      3'd6:    r = DIV_W'(12);
      default: r = DIV_W'(16);
    endcase
    return r;
  endfunction
endpackage

// File: rtl/clkdiv_sync.sv
module clkdiv_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sync_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= d_i;
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= {sync_q[STAGES-2:0], d_i};
    end
  endgenerate

  assign q_o = sync_q[STAGES-1];
endmodule

// File: rtl/clkdiv_core.sv
module clkdiv_core
  import clkdiv_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic [DIV_W-1:0] div_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             pos_o
);
  logic [DIV_W-1:0] div_q, div_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             pos_q, pos_d;
  logic             wrap;
  logic [DIV_W-1:0] half;

  assign wrap = (cnt_q == CNT_W'(div_q - DIV_W'(1)));

  always_comb begin
    // ratio reloads only at period end or while idle
    if (!run_i || wrap) begin
      cnt_d = '0;
      div_d = ratio_f(sel_i);
    end else begin
      cnt_d = cnt_q + CNT_W'(1);
      div_d = div_q;
    end
    half = div_d >> 1;
    if (div_d == DIV_W'(1))      pos_d = 1'b0;
    else if (div_d == DIV_W'(3)) pos_d = (cnt_d == CNT_W'(2));
    else                         pos_d = (DIV_W'(cnt_d) >= half);
    pos_d = pos_d & run_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= ratio_f('0);
      cnt_q <= '0;
      pos_q <= 1'b0;
    end else begin
      div_q <= div_d;
      cnt_q <= cnt_d;
      pos_q <= pos_d;
    end
  end

  assign div_o = div_q;
  assign cnt_o = cnt_q;
  assign pos_o = pos_q;
endmodule

// File: rtl/clkdiv_out.sv
module clkdiv_out
  import clkdiv_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             pos_i,
  output logic             clk_o
);
  logic neg_q;   // extends the /3 high phase by half a cycle
  logic gate_q;  // bypass gate, changes only while clk_i is low

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      neg_q  <= 1'b0;
      gate_q <= 1'b0;
    end else begin
      neg_q  <= run_i && (div_i == DIV_W'(3)) && (cnt_i == CNT_W'(1));
      gate_q <= run_i && (div_i == DIV_W'(1));
    end
  end

  assign clk_o = pos_i | neg_q | (clk_i & gate_q);
endmodule

// File: rtl/clk_out_div.sv
module clk_out_div
  import clkdiv_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [SEL_W-1:0] ratio_sel_i,
  input  logic             pin_is_input_i,
  output logic             clk_o,
  output logic             pin_oe_o
);
  logic             run;
  logic [DIV_W-1:0] div;
  logic [CNT_W-1:0] cnt;
  logic             pos;

  clkdiv_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (en_i & ~pin_is_input_i),
    .q_o    (run)
  );

  clkdiv_core i_core (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .sel_i  (ratio_sel_i),
    .div_o  (div),
    .cnt_o  (cnt),
    .pos_o  (pos)
  );

  clkdiv_out i_out (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .div_i  (div),
    .cnt_i  (cnt),
    .pos_i  (pos),
    .clk_o  (clk_o)
  );

  assign pin_oe_o = run & ~pin_is_input_i;
endmodule

// File: rtl/clk_out_div_chk.sv
module clk_out_div_chk
  import clkdiv_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic             pin_is_input_i,
  input logic             pin_oe_o,
  input logic             run_i,
  input logic [DIV_W-1:0] div_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic             pos_i
);
  a_r6_oe_blocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pin_is_input_i |-> !pin_oe_o);

  a_r5_oe_after_sync: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pin_oe_o |-> $past(en_i, 2));

  a_r7_ratio_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_i != '0) |-> $stable(div_i));

  a_r2_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    DIV_W'(cnt_i) < div_i);

  a_r4_idle_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (cnt_i == '0) && !pos_i);

  a_r1_bypass_no_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div_i == DIV_W'(1)) |-> (cnt_i == '0) && !pos_i);
endmodule

bind clk_out_div clk_out_div_chk i_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .en_i           (en_i),
  .pin_is_input_i (pin_is_input_i),
  .pin_oe_o       (pin_oe_o),
  .run_i          (run),
  .div_i          (div),
  .cnt_i          (cnt),
  .pos_i          (pos)
);

// File: tb/test_clk_out_div.sv
`timescale 1ns/1ps
module test_clk_out_div;
  typedef struct {
    int    per;
    int    hi;
    string req;
  } exp_t;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       en_i = 1'b0;
  logic [2:0] ratio_sel_i = 3'd0;
  logic       pin_is_input_i = 1'b0;
  logic       clk_o;
  logic       pin_oe_o;

  int  n_total = 0;
  int  n_bad = 0;
  int  rise_cnt = 0;
  bit  meas_on = 1'b0;
  bit  have_prev = 1'b0;
  time last_rise = 0;
  time last_fall = 0;
  exp_t exp_q[$];

  always #4 clk_i = ~clk_i;

  clk_out_div i_clk_out_div (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .en_i           (en_i),
    .ratio_sel_i    (ratio_sel_i),
    .pin_is_input_i (pin_is_input_i),
    .clk_o          (clk_o),
    .pin_oe_o       (pin_oe_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_total++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int ratio_of(input int code);
    case (code)
      0: return 1;  1: return 2;  2: return 3;  3: return 4;
      4: return 6;  5: return 8;  6: return 12; default: return 16;
    endcase
  endfunction

  // monitor: pops expected period/high time on each rising edge
  always @(posedge clk_o) begin
    rise_cnt++;
    if (meas_on) begin
      if (have_prev && exp_q.size() > 0) begin
        exp_t e;
        int per, hi;
        e   = exp_q.pop_front();
        per = int'($time - last_rise);
        hi  = int'(last_fall - last_rise);
        chk(per == e.per, e.req, "period_ns", per, e.per);
        chk(hi == e.hi, e.req, "high_ns", hi, e.hi);
      end
      have_prev = 1'b1;
      last_rise = $time;
    end
  end

  always @(negedge clk_o) last_fall = $time;

  task automatic push(input int per, input int hi, input string req);
    exp_t e;
    e.per = per; e.hi = hi; e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk_i);
    meas_on = 1'b0;
  endtask

  task automatic measure_code(input int code);
    int n;
    n = ratio_of(code);
    meas_on = 1'b0;
    ratio_sel_i = 3'(code);
    repeat (40) @(negedge clk_i);
    have_prev = 1'b0;
    for (int k = 0; k < 3; k++) push(8 * n, 4 * n, "R1/R2");
    meas_on = 1'b1;
    drain();
  endtask

  initial begin
    int rc;
    time t0;
    // R3 reset state
    repeat (3) @(negedge clk_i);
    chk(clk_o == 1'b0, "R3", "clk_o in reset", int'(clk_o), 0);
    chk(pin_oe_o == 1'b0, "R3", "pin_oe_o in reset", int'(pin_oe_o), 0);
    rst_ni = 1'b1;
    rc = rise_cnt;
    repeat (10) @(negedge clk_i);
    chk(pin_oe_o == 1'b0, "R3", "pin_oe_o after reset", int'(pin_oe_o), 0);
    chk(rise_cnt == rc, "R3", "clk_o edges after reset", rise_cnt - rc, 0);

    // R5 enable latency and fresh low start, /4
    ratio_sel_i = 3'd3;
    @(negedge clk_i);
    en_i = 1'b1;
    t0 = $time;
    @(negedge clk_i);
    chk(pin_oe_o == 1'b0, "R5", "pin_oe_o after 1 edge", int'(pin_oe_o), 0);
    @(negedge clk_i);
    chk(pin_oe_o == 1'b1, "R5", "pin_oe_o after 2 edges", int'(pin_oe_o), 1);
    @(posedge clk_o);
    chk(int'($time - t0) == 28, "R5", "first clk_o rise ns", int'($time - t0), 28);

    // R1 and R2 for every code
    for (int c = 0; c < 8; c++) measure_code(c);

    // R7 ratio change mid-period: /16 -> /2
    ratio_sel_i = 3'd7;
    repeat (40) @(negedge clk_i);
    have_prev = 1'b0;
    push(72, 64, "R7");
    push(16, 8, "R7");
    push(16, 8, "R7");
    meas_on = 1'b1;
    @(posedge clk_o);
    repeat (3) @(negedge clk_i);
    ratio_sel_i = 3'd1;
    drain();

    // R4 disable holds output low
    @(negedge clk_i);
    en_i = 1'b0;
    repeat (3) @(negedge clk_i);
    chk(clk_o == 1'b0, "R4", "clk_o after disable", int'(clk_o), 0);
    chk(pin_oe_o == 1'b0, "R4", "pin_oe_o after disable", int'(pin_oe_o), 0);
    rc = rise_cnt;
    repeat (40) @(negedge clk_i);
    chk(rise_cnt == rc, "R4", "clk_o edges while disabled", rise_cnt - rc, 0);

    // R6 pad used as input blocks output
    pin_is_input_i = 1'b1;
    en_i = 1'b1;
    #1;
    chk(pin_oe_o == 1'b0, "R6", "pin_oe_o with pad input", int'(pin_oe_o), 0);
    rc = rise_cnt;
    repeat (40) @(negedge clk_i);
    chk(pin_oe_o == 1'b0, "R6", "pin_oe_o held with pad input", int'(pin_oe_o), 0);
    chk(rise_cnt == rc, "R6", "clk_o edges with pad input", rise_cnt - rc, 0);
    pin_is_input_i = 1'b0;
    repeat (3) @(negedge clk_i);
    chk(pin_oe_o == 1'b1, "R6", "pin_oe_o after pad released", int'(pin_oe_o), 1);

    $display("  test done: total=%0d bad=%0d", n_total, n_bad);
    $finish;
  end

  initial begin
    #(100000 * 8);
    n_total++;
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("  test done: total=%0d bad=%0d", n_total, n_bad);
    $finish;
  end
endmodule